// File: doc/BRIEF.md
# Task Check-in Supervisor

This block sits in front of the refresh input of a hardware watchdog. It collects check-ins from several monitored tasks and lets a refresh through only when every task it must watch has shown progress. Each task has a one-bit check-in strobe. A pulse on that strobe sets a sticky flag that holds for the rest of the current evaluation period.

A programmable cycle counter marks the end of each period. At that point the block compares the collected flags against a mask of required tasks. If every required flag is set, it sends one refresh pulse downstream. It latches a bitmap of the required tasks that did not check in, and it raises a sticky indicator the first time any task misses. It then clears all flags so the next period starts empty, whatever the outcome.

The watchdog counter itself is outside this block. Bit i of every per-task vector refers to task i.

Top module: `checkin_supervisor`

## Requirements
- R1: While rst_ni is low, refresh_o, eval_o, miss_o and any_miss_o are all 0.
- R2: A one-cycle high pulse on checkin_i[i], at any cycle of a period except the evaluation cycle, sets the flag of task i until the next evaluation. Pulses for several tasks may arrive together or in separate cycles.
- R3: An evaluation happens when the internal cycle count reaches period_i, so evaluations are period_i+1 cycles apart. The count then restarts at 0. If period_i is lowered below the current count, the evaluation happens at the next cycle. eval_o is high for the one cycle after each evaluation edge.
- R4: refresh_o is high for exactly the cycle in which eval_o is high, and only when every task set in req_mask_i (sampled at the evaluation edge) has its flag set.
- R5: At each evaluation, miss_o becomes req_mask_i & ~flags. It holds that value until the next evaluation.
- R6: Flags of tasks whose req_mask_i bit is 0 have no effect on refresh_o or miss_o. With an all-zero mask, every evaluation gives a refresh.
- R7: Every evaluation clears all flags, whether or not a refresh was issued. A period with no check-ins therefore reports every required task as missing.
- R8: A check-in in the evaluation cycle itself is not counted in that evaluation. It sets the flag for the following period.
- R9: any_miss_o goes high at the first evaluation where miss_o becomes non-zero. It stays high until reset, even after later clean periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| checkin_i | input | N_TASKS | Per-task check-in strobes |
| req_mask_i | input | N_TASKS | Tasks required for a refresh |
| period_i | input | CNT_W | Evaluation period minus one, in cycles |
| refresh_o | output | 1 | One-cycle refresh pulse to the watchdog |
| eval_o | output | 1 | One-cycle marker following each evaluation |
| miss_o | output | N_TASKS | Required tasks missing at the last evaluation |
| any_miss_o | output | 1 | Sticky: some evaluation since reset had a miss |

## Verification
The bench runs with four tasks and sweeps every pair of required mask and check-in pattern, which is 256 periods. Each evaluation's miss bitmap and refresh are compared with mask & ~pattern. This sweep separates the following cases:
- missing required tasks, which must be reported;
- surplus flags on tasks that are not required, which must be ignored;
- the empty mask, which must always refresh.

Directed periods cover further cases:
- check-ins spread one task per cycle, which must accumulate;
- a period with no check-ins after a full one, which shows that the flags are cleared;
- a check-in in the evaluation cycle, which must move to the next period;
- a shortened period while the count is already past the new limit;
- the sticky indicator across a clean period.

// File: rtl/ckp_pkg.sv
package ckp_pkg;
  function automatic logic [31:0] miss_of(input logic [31:0] req, input logic [31:0] flags);
    return req & ~flags;
  endfunction
endpackage

// File: rtl/ckp_period_tmr.sv
module ckp_period_tmr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  // >= keeps a shortened period from wrapping through the full range
  assign tick_o = (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ckp_flag_reg.sv
module ckp_flag_reg #(
  parameter int N_TASKS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [N_TASKS-1:0] checkin_i,
  output logic [N_TASKS-1:0] flags_o
);
  for (genvar g = 0; g < N_TASKS; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flag_q <= 1'b0;
      else if (tick_i) flag_q <= checkin_i[g];  // clear, but keep a same-cycle check-in
      else if (checkin_i[g]) flag_q <= 1'b1;
    end
    assign flags_o[g] = flag_q;
  end
endmodule

// File: rtl/ckp_eval.sv
module ckp_eval #(
  parameter int N_TASKS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [N_TASKS-1:0] flags_i,
  input  logic [N_TASKS-1:0] req_mask_i,
  output logic               refresh_o,
  output logic               eval_o,
  output logic [N_TASKS-1:0] miss_o,
  output logic               any_miss_o
);
  import ckp_pkg::*;

  logic [N_TASKS-1:0] miss_d;
  logic [31:0]        miss_w;
  logic               refresh_q, eval_q, any_q;
  logic [N_TASKS-1:0] miss_q;

  assign miss_w = miss_of(32'(req_mask_i), 32'(flags_i));
  assign miss_d = miss_w[N_TASKS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      refresh_q <= 1'b0;
      eval_q    <= 1'b0;
      miss_q    <= '0;
      any_q     <= 1'b0;
    end else begin
      eval_q    <= tick_i;
      refresh_q <= tick_i && (miss_d == '0);
      if (tick_i) begin
        miss_q <= miss_d;
        if (|miss_d) any_q <= 1'b1;
      end
    end
  end

  assign refresh_o  = refresh_q;
  assign eval_o     = eval_q;
  assign miss_o     = miss_q;
  assign any_miss_o = any_q;
endmodule

// File: rtl/checkin_supervisor.sv
module checkin_supervisor #(
  parameter int N_TASKS = 4,
  parameter int CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_TASKS-1:0] checkin_i,
  input  logic [N_TASKS-1:0] req_mask_i,
  input  logic [CNT_W-1:0]   period_i,
  output logic               refresh_o,
  output logic               eval_o,
  output logic [N_TASKS-1:0] miss_o,
  output logic               any_miss_o
);
  logic               tick;
  logic [N_TASKS-1:0] flags;

  ckp_period_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period_i), .tick_o(tick)
  );

  ckp_flag_reg #(.N_TASKS(N_TASKS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .checkin_i(checkin_i), .flags_o(flags)
  );

  ckp_eval #(.N_TASKS(N_TASKS)) u_eval (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .flags_i(flags),
    .req_mask_i(req_mask_i), .refresh_o(refresh_o), .eval_o(eval_o),
    .miss_o(miss_o), .any_miss_o(any_miss_o)
  );
endmodule

// File: rtl/checkin_supervisor_chk.sv
module checkin_supervisor_chk #(
  parameter int N_TASKS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_TASKS-1:0] req_mask_i,
  input logic               refresh_o,
  input logic               eval_o,
  input logic [N_TASKS-1:0] miss_o,
  input logic               any_miss_o
);
  a_r4_refresh_on_eval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |-> eval_o);
  a_r4_refresh_no_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |-> (miss_o == '0));
  a_r5_miss_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_o |-> $stable(miss_o));
  a_r6_miss_in_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_o |-> ((miss_o & ~$past(req_mask_i)) == '0));
  a_r9_any_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_miss_o |=> any_miss_o);
  a_r9_any_follows_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_o && (miss_o != '0)) |-> any_miss_o);
  always_comb begin
    if (!rst_ni) a_r1_reset_quiet: assert (!refresh_o && !eval_o && miss_o == '0 && !any_miss_o);
  end
endmodule

bind checkin_supervisor checkin_supervisor_chk #(.N_TASKS(N_TASKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_mask_i(req_mask_i), .refresh_o(refresh_o),
  .eval_o(eval_o), .miss_o(miss_o), .any_miss_o(any_miss_o)
);

// File: tb/sim_checkin_supervisor.sv
module sim_checkin_supervisor;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] checkin = '0;
  logic [N-1:0] mask = '0;
  logic [W-1:0] period = 8'd6;
  logic         refresh, eval_w, any_miss;
  logic [N-1:0] miss;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic exp_any = 1'b0;

  always #2 clk = ~clk;

  checkin_supervisor #(.N_TASKS(N), .CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .checkin_i(checkin), .req_mask_i(mask),
    .period_i(period), .refresh_o(refresh), .eval_o(eval_w), .miss_o(miss),
    .any_miss_o(any_miss)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_eval(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!eval_w && n < 1000);
  endtask

  task automatic check_eval(input string req, input logic [N-1:0] exp_miss);
    chk(eval_w === 1'b1, {req, " eval"}, int'(eval_w), 1);
    chk(miss === exp_miss, {req, " miss"}, int'(miss), int'(exp_miss));
    chk(refresh === (exp_miss == '0), {req, " refresh"}, int'(refresh), int'(exp_miss == '0));
    if (exp_miss != '0) exp_any = 1'b1;
    chk(any_miss === exp_any, "R9 any_miss", int'(any_miss), int'(exp_any));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(refresh === 0 && eval_w === 0 && miss === 0 && any_miss === 0, "R1 reset",
        int'({refresh, eval_w, any_miss, miss}), 0);
    rst_n = 1'b1;
    wait_eval(n);
    wait_eval(n);
    chk(n == 7, "R3 period length", n, 7);
    check_eval("R6 empty mask", '0);

    // exhaustive mask x pattern sweep (R4 R5 R6)
    for (int m = 0; m < 16; m++) begin
      for (int f = 0; f < 16; f++) begin
        mask = 4'(m);
        checkin = 4'(f);
        @(negedge clk);
        checkin = '0;
        wait_eval(n);
        check_eval("R5 sweep", 4'(m) & ~4'(f));
      end
    end

    // R2: separate pulses accumulate
    mask = 4'hF;
    for (int i = 0; i < N; i++) begin
      checkin = '0; checkin[i] = 1'b1;
      @(negedge clk);
    end
    checkin = '0;
    wait_eval(n);
    check_eval("R2 accumulate", '0);

    // R7: flags cleared after evaluation
    wait_eval(n);
    check_eval("R7 cleared", 4'hF);

    // R8: check-in in the evaluation cycle
    repeat (6) @(negedge clk);
    checkin = 4'hF;
    @(negedge clk);
    checkin = '0;
    check_eval("R8 not this period", 4'hF);
    wait_eval(n);
    check_eval("R8 next period", '0);
    chk(any_miss === 1'b1, "R9 sticky after clean", int'(any_miss), 1);

    // R3: lowering period below current count
    repeat (4) @(negedge clk);
    period = 8'd2;
    wait_eval(n);
    chk(n == 1, "R3 shortened", n, 1);
    wait_eval(n);
    chk(n == 3, "R3 new period", n, 3);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule